// File: doc/BRIEF.md
# Module Soft-Reset and Clock-Gate Control Register

This block is the per-peripheral control word that holds a module in reset and stops its clock. The top two bits of the 32-bit word carry a hold-in-reset request (bit 31) and a clock-stop request (bit 30). The lower 30 bits are a general field that reads back what was written. Software reaches the word through a single-cycle register port. A plain write strobe replaces the whole word. A set strobe ORs the write data into the word. A clear strobe clears the bits that are 1 in the write data.

The reset request drives the module reset output directly. Its readback on bit 31 follows a settle pipeline, so bit 31 shows a new value only once the module has seen it for three clocks. While the settled readback shows reset held, hardware forces the clock-stop bit to 1 on its own. Software therefore learns that the module is fully quiesced by polling bit 30. To bring the module back, software clears the reset request, waits for bit 31 to read 0, and then clears bit 30.

Top module: `rstgate_ctrl`

## Requirements
- R1: After power-on reset the word reads 0xC000_0000, `mod_rst` is 1 and `mod_clk_en` is 0.
- R2: A plain write (`wr_plain`) loads all 32 bits from `wdata`. Bits 29:0 read back exactly as written.
- R3: A set write (`wr_set`) ORs `wdata` into the word and leaves bits whose data bit is 0 unchanged.
- R4: A clear write (`wr_clr`) clears the bits that are 1 in `wdata` and leaves the others unchanged.
- R5: `rdata[31]` shows a new value of the reset request exactly 3 clocks after the edge at which the request changed.
- R6: On the clock edge after `rdata[31]` reads 1, hardware sets bit 30 with no write. While `rdata[31]` reads 1, a software write that would clear bit 30 is overridden and bit 30 stays 1. Bits 29:0 are not touched by this hardware set.
- R7: `mod_rst` equals the current (unsettled) reset request bit. `mod_clk_en` is the inverse of bit 30.
- R8: When several strobes are high in one cycle, only one takes effect, in the priority order plain, then set, then clear.
- R9: Clearing bit 31, waiting until `rdata[31]` reads 0, and then clearing bit 30 leaves both bits reading 0, with `mod_rst` at 0 and `mod_clk_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_plain | input | 1 | Write strobe: replace the whole word |
| wr_set | input | 1 | Write strobe: OR the data into the word |
| wr_clr | input | 1 | Write strobe: clear the bits that are 1 in the data |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Readback; bit 31 is the settled reset state, bit 30 is clock stop |
| mod_rst | output | 1 | Active-high reset to the module |
| mod_clk_en | output | 1 | Clock enable for the module's gating cell |

## Verification
The bench first walks the full quiesce-and-recover sequence. It samples bit 31 two and three clocks after each change, which separates a correct settle depth from one that is a cycle short or long. It also clears clock stop while the settled reset is still 1, which separates hardware-set priority from software-clear priority. Set and clear writes with mixed data check that unmasked bits survive, and strobe pairs with opposite effects show which strobe wins. A long stretch of random strobes and data is then compared clock by clock against a behavioural model that keeps the reset history in a queue.

// File: rtl/rstgate_pkg.sv
package rstgate_pkg;
  localparam int WORD_W   = 32;
  localparam int HOLD_BIT = 31;
  localparam int GATE_BIT = 30;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_PLAIN = 2'd1,
    WK_SET   = 2'd2,
    WK_CLR   = 2'd3
  } wkind_e;
endpackage

// File: rtl/rstgate_wsel.sv
// Resolves the three write strobes into one write kind (plain > set > clear).
module rstgate_wsel
  import rstgate_pkg::*;
(
  input  logic   wr_plain,
  input  logic   wr_set,
  input  logic   wr_clr,
  output wkind_e kind
);
  always_comb begin
    if (wr_plain)    kind = WK_PLAIN;
    else if (wr_set) kind = WK_SET;
    else if (wr_clr) kind = WK_CLR;
    else             kind = WK_NONE;
  end
endmodule

// File: rtl/rstgate_next.sv
// Next-state of the control word: software update, then hardware clock-stop set.
module rstgate_next
  import rstgate_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  wkind_e       kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cur,
  input  logic         settled,
  output logic [W-1:0] nxt,
  output logic         upd
);
  logic [W-1:0] sw_word;

  always_comb begin
    unique case (kind)
      WK_PLAIN: sw_word = wdata;
      WK_SET:   sw_word = cur | wdata;
      WK_CLR:   sw_word = cur & ~wdata;
      default:  sw_word = cur;
    endcase
    nxt = sw_word;
    if (settled) nxt[GATE_BIT] = 1'b1;
    upd = (kind != WK_NONE) || (settled && !cur[GATE_BIT]);
  end
endmodule

// File: rtl/rstgate_settle.sv
// Shift pipeline giving the reset request's settled readback.
module rstgate_settle #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = d;
    end else begin : g_many
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rstgate_ctrl.sv
// Top: soft-reset / clock-stop control word with plain, set and clear writes.
module rstgate_ctrl
  import rstgate_pkg::*;
#(
  parameter int SETTLE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_plain,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              mod_rst,
  output logic              mod_clk_en
);
  localparam logic [WORD_W-1:0] RESET_WORD =
    (WORD_W'(1) << HOLD_BIT) | (WORD_W'(1) << GATE_BIT);

  wkind_e            kind;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic              word_en;
  logic              settled;

  rstgate_wsel u_wsel (
    .wr_plain (wr_plain),
    .wr_set   (wr_set),
    .wr_clr   (wr_clr),
    .kind     (kind)
  );

  rstgate_next #(.W(WORD_W)) u_next (
    .kind    (kind),
    .wdata   (wdata),
    .cur     (word_q),
    .settled (settled),
    .nxt     (word_d),
    .upd     (word_en)
  );

  rstgate_settle #(.STAGES(SETTLE)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (word_q[HOLD_BIT]),
    .q     (settled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= RESET_WORD;
    else if (word_en) word_q <= word_d;
  end

  always_comb begin
    rdata           = word_q;
    rdata[HOLD_BIT] = settled;
  end

  assign mod_rst    = word_q[HOLD_BIT];
  assign mod_clk_en = ~word_q[GATE_BIT];
endmodule

// File: rtl/rstgate_ctrl_chk.sv
module rstgate_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_plain,
  input logic        wr_set,
  input logic        wr_clr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        mod_rst,
  input logic        mod_clk_en
);
  p_plain_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_plain |=> (rdata[29:0] == $past(wdata[29:0])));

  p_set_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !wr_plain && wdata[31]) |=> mod_rst);

  p_clr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_plain && !wr_set && wdata[31]) |=> !mod_rst);

  p_settle_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[31]) |-> $past(mod_rst, 3));

  p_settle_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata[31]) |-> !$past(mod_rst, 3));

  p_gate_auto_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31] |=> (rdata[30] && !mod_clk_en));
endmodule

bind rstgate_ctrl rstgate_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_plain   (wr_plain),
  .wr_set     (wr_set),
  .wr_clr     (wr_clr),
  .wdata      (wdata),
  .rdata      (rdata),
  .mod_rst    (mod_rst),
  .mod_clk_en (mod_clk_en)
);

// File: tb/rstgate_ctrl_test.sv
`timescale 1ns/1ps
module rstgate_ctrl_test;
  localparam int SETTLE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_plain = 1'b0;
  logic        wr_set = 1'b0;
  logic        wr_clr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mod_rst;
  logic        mod_clk_en;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rstgate_ctrl #(.SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .wr_plain(wr_plain), .wr_set(wr_set),
    .wr_clr(wr_clr), .wdata(wdata), .rdata(rdata), .mod_rst(mod_rst),
    .mod_clk_en(mod_clk_en)
  );

  // Behavioural reference model
  bit          m_sr, m_gate;
  logic [29:0] m_field;
  bit          hist[$];
  logic [31:0] m_word;
  bit          m_settled;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sr = 1; m_gate = 1; m_field = '0;
      hist.delete();
      for (int i = 0; i < SETTLE; i++) hist.push_back(1'b1);
    end else begin
      m_settled = hist[SETTLE-1];
      m_word = {m_sr, m_gate, m_field};
      if (wr_plain)    m_word = wdata;
      else if (wr_set) m_word = m_word | wdata;
      else if (wr_clr) m_word = m_word & ~wdata;
      if (m_settled) m_word[30] = 1'b1;
      hist.push_front(m_sr);
      void'(hist.pop_back());
      m_sr = m_word[31]; m_gate = m_word[30]; m_field = m_word[29:0];
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      check("R5 model rdata[31]", 32'(rdata[31]), 32'(hist[SETTLE-1]));
      check("R6 model rdata[30]", 32'(rdata[30]), 32'(m_gate));
      check("R2 model rdata[29:0]", 32'(rdata[29:0]), 32'(m_field));
      check("R7 model mod_rst", 32'(mod_rst), 32'(m_sr));
      check("R7 model mod_clk_en", 32'(mod_clk_en), 32'(!m_gate));
    end
  end

  // called at a negedge; the write lands on the next posedge
  task automatic wr(bit p, bit s, bit c, logic [31:0] d);
    wr_plain = p; wr_set = s; wr_clr = c; wdata = d;
    @(negedge clk);
    wr_plain = 0; wr_set = 0; wr_clr = 0; wdata = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1;
    idle(2);
    chk_on = 1;
    // R1 reset state
    check("R1 rdata", rdata, 32'hC000_0000);
    check("R1 mod_rst", 32'(mod_rst), 32'd1);
    check("R1 mod_clk_en", 32'(mod_clk_en), 32'd0);

    // R2 plain write; R6 gate held while settled reset is 1
    wr(1, 0, 0, 32'h0000_1234);
    check("R2 plain write", rdata, 32'hC000_1234);
    check("R7 mod_rst after clear", 32'(mod_rst), 32'd0);
    idle(2);
    check("R5 not yet settled", rdata, 32'hC000_1234);
    idle(1);
    check("R5 settled at 3", rdata, 32'h4000_1234);
    wr(0, 0, 1, 32'h4000_0000);
    check("R9 gate cleared", rdata, 32'h0000_1234);
    check("R9 clk_en", 32'(mod_clk_en), 32'd1);

    // R3 / R4 masked set and clear
    wr(0, 1, 0, 32'h0000_00F0);
    check("R3 set alias", rdata, 32'h0000_12F4);
    wr(0, 0, 1, 32'h0000_0204);
    check("R4 clear alias", rdata, 32'h0000_10F0);

    // Soft reset assert: R5 readback, R6 auto gate
    wr(0, 1, 0, 32'h8000_0000);
    check("R7 mod_rst asserted", 32'(mod_rst), 32'd1);
    check("R5 readback lag", rdata, 32'h0000_10F0);
    idle(2);
    check("R5 readback pre", rdata, 32'h0000_10F0);
    idle(1);
    check("R5 readback set", rdata, 32'h8000_10F0);
    check("R6 not gated yet", 32'(mod_clk_en), 32'd1);
    idle(1);
    check("R6 auto gate", rdata, 32'hC000_10F0);
    check("R6 clk_en off", 32'(mod_clk_en), 32'd0);

    // R6 override of early gate clear, then R9 recovery
    wr(0, 0, 1, 32'h8000_0000);
    wr(0, 0, 1, 32'h4000_0000);
    check("R6 early clear overridden", rdata, 32'hC000_10F0);
    idle(2);
    check("R9 reset readback 0", rdata, 32'h4000_10F0);
    wr(0, 0, 1, 32'h4000_0000);
    check("R9 running", rdata, 32'h0000_10F0);
    check("R9 mod_rst", 32'(mod_rst), 32'd0);
    check("R9 clk_en", 32'(mod_clk_en), 32'd1);

    // R8 priority
    wr(1, 0, 1, 32'h0000_0001);
    check("R8 plain over clear", rdata, 32'h0000_0001);
    wr(0, 1, 1, 32'h0000_0100);
    check("R8 set over clear", rdata, 32'h0000_0101);
    wr(1, 1, 0, 32'h0000_0010);
    check("R8 plain over set", rdata, 32'h0000_0010);

    // random strobes, compared against the model every clock
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      wr(r[0] & r[3], r[1], r[2], $urandom);
    end
    idle(4);
    done = 1;
    summary();
    $finish;
  end
endmodule